// File: doc/BRIEF.md
# I2C Slave Memory Front End

This block is the bus-facing side of a byte-addressed memory with 256 locations. It watches the two I2C lines with the system clock and finds START, repeated START and STOP conditions. It collects address and data bytes MSB first and answers each byte in the ninth bit. Read data goes back to the master through an open-drain pull-down. Once the block recognises its own slave address, it takes the next written byte as a memory pointer. Every later written byte becomes a write strobe at the pointer. Reads fetch from the pointer. The pointer advances by one after each byte and wraps from FFh to 00h.

A strap input chooses the slave address. With the strap low, the address is fixed. With the strap high, the address comes from a slave-address register inside the block. That register is reloaded whenever the memory location it shadows is written over the bus. An external busy flag reports an ongoing nonvolatile write. While that flag is set, the block refuses its own address, so a master can poll with repeated addressing until the write has finished.

Top module: `i2c_mem_front`

## Requirements
- R1: With `addrSelect` low, the block acknowledges the address bytes A2h (write) and A3h (read) and answers NACK to any other address byte.
- R2: With `addrSelect` high, the slave address is taken from the internal slave-address register, which resets to A0h. A2h is then answered with NACK.
- R3: A bus write to location 9Fh loads the slave-address register. Only its bits 7..1 are compared with the address byte, so a stored B5h makes the block answer B4h (write) and B5h (read). The old address A0h is then refused.
- R4: A START (SDA falling while SCL is high) begins a new address phase from any state, including in the middle of a transfer (repeated START). A STOP (SDA rising while SCL is high) returns the block to idle.
- R5: In a write transfer, the byte after the address byte loads the memory pointer. Each following byte is acknowledged and produces exactly one `memWrEn` strobe at the pointer with that byte, and the pointer then advances by one. Read and write strobes never coincide.
- R6: In a read transfer, bytes are driven MSB first from the pointer, and SDA changes only while SCL is low. The pointer advances by one after each fetch and wraps from FFh to 00h. Writes also wrap.
- R7: After an address byte that does not match, the block answers NACK, leaves SDA released, and issues no memory strobes for any byte until the next START.
- R8: While `writeBusy` is high, the block answers NACK to its own address. Once the flag is low, the same address byte is acknowledged.
- R9: A master NACK after a read byte ends the transfer. SDA stays released and no further read strobe is issued.
- R10: During and directly after reset, `sdaPullLow`, `memWrEn` and `memRdEn` are all low.
- R11: SDA is open-drain. `sdaPullLow` is high only to send a 0 (an ACK, or a data bit of 0), so a data bit of 1 reads back high on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level (wired-AND bus) |
| sdaPullLow | output | 1 | 1 pulls SDA low, 0 releases it |
| addrSelect | input | 1 | 0: fixed address A2h, 1: stored address register |
| writeBusy | input | 1 | Nonvolatile write in progress; own address is refused |
| memAddr | output | 8 | Memory pointer for reads and writes |
| memWrEn | output | 1 | One-cycle write strobe |
| memWrData | output | 8 | Write data, valid with `memWrEn` |
| memRdEn | output | 1 | One-cycle read strobe; data expected on the next cycle |
| memRdData | input | 8 | Read data, registered by the memory one cycle after `memRdEn` |

## Verification
The bench focuses on corner cases that a plausible bug would break. A pointer that does not wrap would write or read FFh+1 into the wrong place, and the FEh..00h bursts would show the stray location. A decoder that ignores the strap, or compares bit 0 of the stored address, would refuse B4h or accept A0h after the register has been reprogrammed. An address mismatch that is not latched until the next START would let later bytes through as writes; the scoreboard reports any such write as unexpected. Repeated START inside a write and inside a read, busy polling, and a master NACK followed by a count of read strobes catch a state machine that resumes at the wrong byte, acknowledges while busy, or prefetches after the final byte.

// File: rtl/i2cmf_pkg.sv
package i2cmf_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {SDA_RELEASE, SDA_ACK, SDA_DATA} sdaMode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RX_ACKWAIT, ST_RX_ACK, ST_TX, ST_TX_ACK, ST_TX_END
  } busState_e;

  typedef enum logic [1:0] {BK_SLAVE, BK_OFFSET, BK_DATA} byteKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     shiftIn;
    logic     txShift;
    logic     cntClr;
    logic     ptrLoad;
    logic     memWr;
    logic     memRd;
    sdaMode_e sdaMode;
  } dpStrobe_t;
endpackage

// File: rtl/i2cmf_sync.sv
module i2cmf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaBit,
  output logic sclRise,
  output logic sclFall,
  output logic busStart,
  output logic busStop
);
  localparam int PIPE_W = STAGES + 1;

  logic [PIPE_W-1:0] sclPipe;
  logic [PIPE_W-1:0] sdaPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[PIPE_W-2:0], sclIn};
      sdaPipe <= {sdaPipe[PIPE_W-2:0], sdaIn};
    end
  end

  logic sclNow, sclOld, sdaNow, sdaOld;
  assign sclNow = sclPipe[STAGES-1];
  assign sclOld = sclPipe[STAGES];
  assign sdaNow = sdaPipe[STAGES-1];
  assign sdaOld = sdaPipe[STAGES];

  assign sdaBit   = sdaNow;
  assign sclRise  = sclNow & ~sclOld;
  assign sclFall  = ~sclNow & sclOld;
  assign busStart = sclNow & sclOld & sdaOld & ~sdaNow;
  assign busStop  = sclNow & sclOld & ~sdaOld & sdaNow;
endmodule

// File: rtl/i2cmf_datapath.sv
module i2cmf_datapath
  import i2cmf_pkg::*;
#(
  parameter logic [BYTE_W-1:0] FIXED_SLAVE   = 8'hA2,
  parameter logic [BYTE_W-1:0] RESET_SLAVE   = 8'hA0,
  parameter logic [BYTE_W-1:0] SLAVE_REG_LOC = 8'h9F
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              sdaBit,
  input  logic              addrSelect,
  input  logic [BYTE_W-1:0] memRdData,
  output logic              cntLast,
  output logic              addrMatch,
  output logic              rwBit,
  output logic              sdaPullLow,
  output logic [BYTE_W-1:0] memAddr,
  output logic              memWrEn,
  output logic [BYTE_W-1:0] memWrData,
  output logic              memRdEn
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] rxSr, txSr, ptr, slaveReg;
  logic [CNT_W-1:0]  bitCnt;
  logic              rdPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSr     <= '0;
      txSr     <= '1;
      ptr      <= '0;
      slaveReg <= RESET_SLAVE;
      bitCnt   <= '0;
      rdPend   <= 1'b0;
    end else begin
      rdPend <= strb.memRd;
      if (strb.cntClr) begin
        bitCnt <= '0;
      end else if (strb.shiftIn || strb.txShift) begin
        bitCnt <= bitCnt + 1'b1;
      end
      if (strb.shiftIn) begin
        rxSr <= {rxSr[BYTE_W-2:0], sdaBit};
      end
      if (rdPend) begin
        txSr <= memRdData;
      end else if (strb.txShift) begin
        txSr <= {txSr[BYTE_W-2:0], 1'b1};
      end
      if (strb.ptrLoad) begin
        ptr <= rxSr;
      end else if (strb.memWr || rdPend) begin
        ptr <= ptr + 1'b1;
      end
      if (strb.memWr && ptr == SLAVE_REG_LOC) begin
        slaveReg <= rxSr;
      end
    end
  end

  logic [BYTE_W-1:0] ownAddr;
  assign ownAddr   = addrSelect ? slaveReg : FIXED_SLAVE;
  assign addrMatch = rxSr[BYTE_W-1:1] == ownAddr[BYTE_W-1:1];
  assign rwBit     = rxSr[0];
  assign cntLast   = bitCnt == CNT_END;

  assign sdaPullLow = (strb.sdaMode == SDA_ACK) ||
                      (strb.sdaMode == SDA_DATA && !txSr[BYTE_W-1]);
  assign memAddr   = ptr;
  assign memWrEn   = strb.memWr;
  assign memWrData = rxSr;
  assign memRdEn   = strb.memRd;
endmodule

// File: rtl/i2cmf_control.sv
module i2cmf_control
  import i2cmf_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      busStart,
  input  logic      busStop,
  input  logic      sclRise,
  input  logic      sclFall,
  input  logic      sdaBit,
  input  logic      cntLast,
  input  logic      addrMatch,
  input  logic      rwBit,
  input  logic      writeBusy,
  output dpStrobe_t strb
);
  busState_e state, stateNext;
  byteKind_e kind, kindNext;
  sdaMode_e  mode, modeNext;
  logic      readDir, readDirNext;
  logic      acked, ackedNext;

  always_comb begin
    stateNext   = state;
    kindNext    = kind;
    modeNext    = mode;
    readDirNext = readDir;
    ackedNext   = acked;
    strb        = '0;

    if (busStart) begin
      stateNext    = ST_RX;
      kindNext     = BK_SLAVE;
      modeNext     = SDA_RELEASE;
      strb.cntClr  = 1'b1;
    end else if (busStop) begin
      stateNext = ST_IDLE;
      modeNext  = SDA_RELEASE;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_RX: begin
          if (sclRise) begin
            strb.shiftIn = 1'b1;
            if (cntLast) stateNext = ST_RX_ACKWAIT;
          end
        end
        ST_RX_ACKWAIT: begin
          if (sclFall) begin
            unique case (kind)
              BK_SLAVE: begin
                if (addrMatch && !writeBusy) begin
                  modeNext    = SDA_ACK;
                  readDirNext = rwBit;
                  strb.memRd  = rwBit;
                  stateNext   = ST_RX_ACK;
                end else begin
                  stateNext = ST_IDLE;
                end
              end
              BK_OFFSET: begin
                strb.ptrLoad = 1'b1;
                modeNext     = SDA_ACK;
                stateNext    = ST_RX_ACK;
              end
              default: begin
                strb.memWr = 1'b1;
                modeNext   = SDA_ACK;
                stateNext  = ST_RX_ACK;
              end
            endcase
          end
        end
        ST_RX_ACK: begin
          if (sclFall) begin
            strb.cntClr = 1'b1;
            if (kind == BK_SLAVE && readDir) begin
              modeNext  = SDA_DATA;
              stateNext = ST_TX;
            end else begin
              modeNext  = SDA_RELEASE;
              kindNext  = (kind == BK_SLAVE) ? BK_OFFSET : BK_DATA;
              stateNext = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (sclFall) begin
            strb.txShift = 1'b1;
            if (cntLast) begin
              modeNext  = SDA_RELEASE;
              stateNext = ST_TX_ACK;
            end
          end
        end
        ST_TX_ACK: begin
          if (sclRise) begin
            ackedNext  = !sdaBit;
            strb.memRd = !sdaBit;
            stateNext  = ST_TX_END;
          end
        end
        ST_TX_END: begin
          if (sclFall) begin
            if (acked) begin
              strb.cntClr = 1'b1;
              modeNext    = SDA_DATA;
              stateNext   = ST_TX;
            end else begin
              stateNext = ST_IDLE;
            end
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
    strb.sdaMode = mode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      kind    <= BK_SLAVE;
      mode    <= SDA_RELEASE;
      readDir <= 1'b0;
      acked   <= 1'b0;
    end else begin
      state   <= stateNext;
      kind    <= kindNext;
      mode    <= modeNext;
      readDir <= readDirNext;
      acked   <= ackedNext;
    end
  end
endmodule

// File: rtl/i2c_mem_front.sv
module i2c_mem_front
  import i2cmf_pkg::*;
#(
  parameter int                SYNC_STAGES   = 2,
  parameter logic [BYTE_W-1:0] FIXED_SLAVE   = 8'hA2,
  parameter logic [BYTE_W-1:0] RESET_SLAVE   = 8'hA0,
  parameter logic [BYTE_W-1:0] SLAVE_REG_LOC = 8'h9F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaPullLow,
  input  logic              addrSelect,
  input  logic              writeBusy,
  output logic [BYTE_W-1:0] memAddr,
  output logic              memWrEn,
  output logic [BYTE_W-1:0] memWrData,
  output logic              memRdEn,
  input  logic [BYTE_W-1:0] memRdData
);
  logic sdaBit, sclRise, sclFall, busStart, busStop;
  logic cntLast, addrMatch, rwBit;
  dpStrobe_t strb;

  i2cmf_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sdaBit(sdaBit), .sclRise(sclRise), .sclFall(sclFall),
    .busStart(busStart), .busStop(busStop)
  );

  i2cmf_control uCtrl (
    .clk(clk), .rstN(rstN), .busStart(busStart), .busStop(busStop),
    .sclRise(sclRise), .sclFall(sclFall), .sdaBit(sdaBit),
    .cntLast(cntLast), .addrMatch(addrMatch), .rwBit(rwBit),
    .writeBusy(writeBusy), .strb(strb)
  );

  i2cmf_datapath #(
    .FIXED_SLAVE(FIXED_SLAVE), .RESET_SLAVE(RESET_SLAVE),
    .SLAVE_REG_LOC(SLAVE_REG_LOC)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaBit(sdaBit),
    .addrSelect(addrSelect), .memRdData(memRdData),
    .cntLast(cntLast), .addrMatch(addrMatch), .rwBit(rwBit),
    .sdaPullLow(sdaPullLow), .memAddr(memAddr), .memWrEn(memWrEn),
    .memWrData(memWrData), .memRdEn(memRdEn)
  );
endmodule

// File: rtl/i2c_mem_front_chk.sv
module i2c_mem_front_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sclIn,
  input logic       sdaPullLow,
  input logic [7:0] memAddr,
  input logic       memWrEn,
  input logic       memRdEn
);
  logic wasReset = 1'b0;

  always_ff @(posedge clk) begin
    wasReset <= !rstN;
    if (!rstN && wasReset) begin
      assert_reset_idle_R10: assert (!sdaPullLow && !memWrEn && !memRdEn)
        else $error("R10 outputs active during reset");
    end
  end

  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(memWrEn && memRdEn));

  assert_write_acked_R5: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> sdaPullLow);

  assert_write_advance_R5: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> memAddr == 8'($past(memAddr) + 8'd1));

  assert_read_advance_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(memRdEn, 2) |-> memAddr == 8'($past(memAddr, 2) + 8'd1));

  assert_sda_scl_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sdaPullLow != $past(sdaPullLow)) |-> !sclIn);
endmodule

bind i2c_mem_front i2c_mem_front_chk uChk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaPullLow(sdaPullLow),
  .memAddr(memAddr), .memWrEn(memWrEn), .memRdEn(memRdEn)
);

// File: tb/i2c_mem_front_test.sv
`timescale 1ns/1ps
module i2c_mem_front_test;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic addrSelect = 1'b0, writeBusy = 1'b0;
  logic sdaPullLow, memWrEn, memRdEn;
  logic [7:0] memAddr, memWrData, memRdData;
  logic busSda;

  int checks = 0, fails = 0, rdCount = 0;
  bit done = 1'b0;

  logic [7:0] mem [256];
  logic [7:0] model [256];
  logic [15:0] wrQ[$];

  always #2 clk = ~clk;
  assign busSda = sdaM & ~sdaPullLow;

  i2c_mem_front uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(busSda),
    .sdaPullLow(sdaPullLow), .addrSelect(addrSelect), .writeBusy(writeBusy),
    .memAddr(memAddr), .memWrEn(memWrEn), .memWrData(memWrData),
    .memRdEn(memRdEn), .memRdData(memRdData)
  );

  // memory model, registered read
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
      memRdData <= 8'h00;
    end else begin
      if (memWrEn) mem[memAddr] <= memWrData;
      if (memRdEn) memRdData <= mem[memAddr];
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // write monitor: scoreboard pop
  always @(negedge clk) begin
    if (rstN && memWrEn) begin
      if (wrQ.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R7 unexpected write actual=%0h expected=none", {memAddr, memWrData});
      end else begin
        logic [15:0] e;
        e = wrQ.pop_front();
        check({memAddr, memWrData} == e, "R5 write item", {memAddr, memWrData}, e);
      end
    end
    if (rstN && memRdEn) rdCount++;
  end

  task automatic waitQ(); repeat (Q) @(negedge clk); endtask

  task automatic busStartCond();
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b0; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic busStopCond();
    sdaM = 1'b0; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b1; waitQ();
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; waitQ(); sclM = 1'b1; waitQ(); waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic getBit(output logic b);
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ(); b = busSda; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] v, output bit acked);
    logic a;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    getBit(a);
    acked = !a;
  endtask

  task automatic pushWrite(input logic [7:0] a, input logic [7:0] d);
    wrQ.push_back({a, d});
    model[a] = d;
  endtask

  task automatic getByte(input bit giveAck, input logic [7:0] exp, input string req);
    logic [7:0] v;
    logic b;
    for (int i = 7; i >= 0; i--) begin
      getBit(b);
      v[i] = b;
    end
    sendBit(giveAck ? 1'b0 : 1'b1);
    check(v == exp, req, v, exp);
  endtask

  task automatic expAck(input logic [7:0] v, input bit want, input string req);
    bit a;
    sendByte(v, a);
    check(a == want, req, a, want);
  endtask

  initial begin
    int rdBefore;
    for (int i = 0; i < 256; i++) model[i] = 8'(i) ^ 8'h5A;
    repeat (5) @(negedge clk);
    check(!sdaPullLow && !memWrEn && !memRdEn, "R10 reset outputs", {sdaPullLow, memWrEn, memRdEn}, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check(!sdaPullLow && !memWrEn && !memRdEn, "R10 after reset", {sdaPullLow, memWrEn, memRdEn}, 0);

    // R1 R5: fixed address write burst
    busStartCond();
    expAck(8'hA2, 1, "R1 fixed address ack");
    expAck(8'h10, 1, "R5 pointer ack");
    pushWrite(8'h10, 8'h11); expAck(8'h11, 1, "R5 data ack");
    pushWrite(8'h11, 8'h22); expAck(8'h22, 1, "R5 data ack");
    busStopCond();

    // R1 R7: other address refused and ignored
    busStartCond();
    expAck(8'hA0, 0, "R1 foreign address nack");
    expAck(8'h10, 0, "R7 ignored byte nack");
    expAck(8'h99, 0, "R7 ignored byte nack");
    busStopCond();

    // R6 R9 R4: read with repeated START, master NACK ends
    busStartCond();
    expAck(8'hA2, 1, "R1 write address ack");
    expAck(8'h10, 1, "R5 pointer ack");
    rdBefore = rdCount;
    busStartCond();
    expAck(8'hA3, 1, "R1 read address ack");
    getByte(1, model[8'h10], "R6 R11 read byte 0");
    getByte(0, model[8'h11], "R6 R11 read byte 1");
    repeat (30) @(negedge clk);
    check(rdCount - rdBefore == 2, "R9 no fetch after nack", rdCount - rdBefore, 2);
    check(!sdaPullLow, "R9 sda released", sdaPullLow, 0);
    busStopCond();

    // R6 wrap on write and read
    busStartCond();
    expAck(8'hA2, 1, "R1 address ack");
    expAck(8'hFE, 1, "R5 pointer ack");
    pushWrite(8'hFE, 8'hAA); expAck(8'hAA, 1, "R6 data ack");
    pushWrite(8'hFF, 8'hBB); expAck(8'hBB, 1, "R6 data ack");
    pushWrite(8'h00, 8'hCC); expAck(8'hCC, 1, "R6 wrapped write ack");
    busStopCond();
    busStartCond();
    expAck(8'hA2, 1, "R1 address ack");
    expAck(8'hFF, 1, "R5 pointer ack");
    busStartCond();
    expAck(8'hA3, 1, "R1 read address ack");
    getByte(1, model[8'hFF], "R6 read at FF");
    getByte(1, model[8'h00], "R6 read wrapped 00");
    getByte(0, model[8'h01], "R6 read 01");
    busStopCond();

    // R2: stored address
    addrSelect = 1'b1;
    busStartCond();
    expAck(8'hA2, 0, "R2 fixed address refused");
    busStopCond();
    busStartCond();
    expAck(8'hA0, 1, "R2 default stored address ack");
    expAck(8'h40, 1, "R5 pointer ack");
    pushWrite(8'h40, 8'h5C); expAck(8'h5C, 1, "R5 data ack");
    busStopCond();

    // R3: reprogram slave address, bit 0 ignored
    busStartCond();
    expAck(8'hA0, 1, "R3 address ack");
    expAck(8'h9F, 1, "R3 pointer ack");
    pushWrite(8'h9F, 8'hB5); expAck(8'hB5, 1, "R3 address reg write");
    busStopCond();
    busStartCond();
    expAck(8'hA0, 0, "R3 old address refused");
    busStopCond();
    busStartCond();
    expAck(8'hB4, 1, "R3 new write address");
    expAck(8'h40, 1, "R3 pointer ack");
    busStartCond();
    expAck(8'hB5, 1, "R3 new read address");
    getByte(0, model[8'h40], "R3 read via new address");
    busStopCond();

    // R8: busy polling
    writeBusy = 1'b1;
    busStartCond();
    expAck(8'hB4, 0, "R8 busy nack");
    busStopCond();
    writeBusy = 1'b0;
    busStartCond();
    expAck(8'hB4, 1, "R8 ack when ready");
    busStopCond();

    // R4: repeated START inside a write
    busStartCond();
    expAck(8'hB4, 1, "R4 address ack");
    expAck(8'h20, 1, "R4 pointer ack");
    pushWrite(8'h20, 8'h01); expAck(8'h01, 1, "R4 data ack");
    busStartCond();
    expAck(8'hB4, 1, "R4 restart address ack");
    expAck(8'h30, 1, "R4 new pointer ack");
    pushWrite(8'h30, 8'h02); expAck(8'h02, 1, "R4 data after restart");
    busStopCond();
    repeat (20) @(negedge clk);
    check(wrQ.size() == 0, "R5 all writes seen", wrQ.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule